// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Word

This block is the arithmetic half of a small accumulator datapath. It owns an 8-bit accumulator, an 8-bit B result register and an 8-bit status word. On each strobed operation it combines the accumulator with a B operand, writes the result back and updates the carry, half-carry and overflow flags on the same clock edge. The five operations are add, add with carry-in, subtract with borrow, unsigned multiply and unsigned divide. Multiply and divide return two bytes, one to the accumulator and one to the B register.

Software reaches the accumulator and the status word through a one-cycle register write port at fixed addresses. The status word also holds two general-purpose software flags and a two-bit working-register bank selector. The block turns the selector into the base address of the active eight-byte bank. The lowest status bit is a parity indicator. It is derived continuously from the accumulator and cannot be written.

All operations complete in one cycle. There is no busy signal, and an operation may be issued on every clock.

Top module: `acc_alu_core`

## Requirements
- R1: The carry flag (status bit 7) is set when an add or add-with-carry carries out of bit 7, or when a subtract needs a borrow into bit 7. It is cleared otherwise, and multiply and divide always clear it.
- R2: The half-carry flag (status bit 6) is set when an add carries out of bit 3, or when a subtract borrows from the upper nibble. It is cleared otherwise, and multiply and divide always clear it.
- R3: The overflow flag (status bit 2) is set on two's-complement sign overflow of add, add-with-carry and subtract, on a multiply product above 255, and on divide with a zero divisor. Each of the five operations clears it in every other case.
- R4: Status bit 0 is 1 when the accumulator holds an odd number of ones and 0 otherwise. It follows the accumulator and ignores writes.
- R5: The status word reads as {carry, half-carry, user flag A, bank[1], bank[0], overflow, user flag B, parity}, bit 7 first. It resets to 0x00. A register write at address 0xD0 loads bits 7 to 1. The user flags (bits 5 and 1) change only through such writes.
- R6: `bank_base` equals the bank field (status bits 4:3) times 8, giving 0x00, 0x08, 0x10 or 0x18.
- R7: A register write at address 0xE0 loads the accumulator. The accumulator and B reset to 0x00. Writes to any other address change nothing.
- R8: Add uses a carry-in of 0. Add-with-carry uses the current carry flag as carry-in. Subtract uses the current carry flag as borrow-in.
- R9: Multiply writes the low product byte to the accumulator and the high byte to B.
- R10: Divide writes the quotient to the accumulator and the remainder to B. With a zero divisor, both registers keep their values and only the flags change.
- R11: When an operation and a status write fall in the same cycle, the operation sets carry, half-carry and overflow, and the written value is kept for the user flags and the bank field. When an operation and an accumulator write coincide, the operation result is loaded.
- R12: `op_code` encodes 0 = add, 1 = add-with-carry, 2 = subtract-with-borrow, 3 = multiply, 4 = divide. Codes 5 to 7 have no effect. Results and flags appear after the clock edge that samples `op_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Execute `op_code` this cycle |
| op_code | input | 3 | Operation select (see R12) |
| b_in | input | 8 | Second operand / divisor / multiplier |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| acc_q | output | 8 | Accumulator |
| b_q | output | 8 | High product byte or remainder |
| psw_q | output | 8 | Status word |
| bank_base | output | 5 | Base address of the selected register bank |

## Verification
The bound checker watches these behaviours on every cycle:
- parity always agrees with the accumulator;
- user flags and bank field hold unless a status write occurs, and then take the written bits even when an operation coincides;
- reserved codes leave all outputs still;
- multiply clears carry and half-carry and flags a non-zero high byte;
- a zero-divisor divide sets overflow and freezes both data registers.

Only the bench's scenarios can show the arithmetic values and the carry, half-carry and sign-overflow boundaries. The cases it drives include 0x7F+1, 0xFF+1 with a stale carry, borrows through zero and 0x80, products above and below 256, and a real quotient with remainder. It also covers both same-cycle collisions, which are checked against an independent model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam logic [7:0] ADDR_STATUS = 8'hD0;
    localparam logic [7:0] ADDR_ACCUM  = 8'hE0;

    localparam int BIT_CY  = 7;
    localparam int BIT_AC  = 6;
    localparam int BIT_UFA = 5;
    localparam int BIT_RSH = 4;
    localparam int BIT_RSL = 3;
    localparam int BIT_OV  = 2;
    localparam int BIT_UFB = 1;
    localparam int BIT_PAR = 0;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUBB = 3'd2,
        OP_MUL  = 3'd3,
        OP_DIV  = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } arith_flags_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o,
    output logic          ac_o,
    output logic          ov_o
);
    localparam int NIB = 4;

    logic [DW:0]  wide;
    logic [NIB:0] low;

    always_comb begin
        if (sub_i) begin
            wide = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin_i};
            low  = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - {{NIB{1'b0}}, cin_i};
        end else begin
            wide = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
            low  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
        end
        res_o = wide[DW-1:0];
        cy_o  = wide[DW];
        ac_o  = low[NIB];
        if (sub_i)
            ov_o = (a_i[DW-1] != b_i[DW-1]) && (wide[DW-1] != a_i[DW-1]);
        else
            ov_o = (a_i[DW-1] == b_i[DW-1]) && (wide[DW-1] != a_i[DW-1]);
    end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          div_i,
    output logic [DW-1:0] lo_o,
    output logic [DW-1:0] hi_o,
    output logic          ov_o,
    output logic          wr_o
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] prod;
    logic [DW-1:0] quo;
    logic [DW-1:0] rem;
    logic [DW:0]   trial;

    assign prod = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};

    // restoring division, one quotient bit per unrolled step
    always_comb begin
        rem   = '0;
        quo   = '0;
        trial = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            trial = {rem, a_i[i]};
            if (trial >= {1'b0, b_i}) begin
                trial  = trial - {1'b0, b_i};
                quo[i] = 1'b1;
            end
            rem = trial[DW-1:0];
        end
    end

    always_comb begin
        if (div_i) begin
            lo_o = quo;
            hi_o = rem;
            ov_o = (b_i == '0);
            wr_o = (b_i != '0);
        end else begin
            lo_o = prod[DW-1:0];
            hi_o = prod[PW-1:DW];
            ov_o = (prod[PW-1:DW] != '0);
            wr_o = 1'b1;
        end
    end
endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status
    import acc_alu_pkg::*;
#(
    parameter int DW      = 8,
    parameter int BANK_SZ = 8,
    localparam int BSH    = $clog2(BANK_SZ),
    localparam int BBW    = 2 + BSH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sw_we_i,
    input  logic [7:0]     sw_data_i,
    input  logic           ar_we_i,
    input  arith_flags_t   ar_flags_i,
    input  logic [DW-1:0]  acc_i,
    output logic [7:0]     psw_o,
    output logic [BBW-1:0] bank_base_o
);
    logic         ufa_q, ufb_q;
    logic [1:0]   bank_q;
    arith_flags_t fl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ufa_q  <= 1'b0;
            ufb_q  <= 1'b0;
            bank_q <= 2'b00;
            fl_q   <= '0;
        end else begin
            if (sw_we_i) begin
                ufa_q  <= sw_data_i[BIT_UFA];
                ufb_q  <= sw_data_i[BIT_UFB];
                bank_q <= sw_data_i[BIT_RSH:BIT_RSL];
            end
            if (ar_we_i)
                fl_q <= ar_flags_i;
            else if (sw_we_i)
                fl_q <= '{cy: sw_data_i[BIT_CY], ac: sw_data_i[BIT_AC], ov: sw_data_i[BIT_OV]};
        end
    end

    always_comb begin
        psw_o          = '0;
        psw_o[BIT_CY]  = fl_q.cy;
        psw_o[BIT_AC]  = fl_q.ac;
        psw_o[BIT_UFA] = ufa_q;
        psw_o[BIT_RSH] = bank_q[1];
        psw_o[BIT_RSL] = bank_q[0];
        psw_o[BIT_OV]  = fl_q.ov;
        psw_o[BIT_UFB] = ufb_q;
        psw_o[BIT_PAR] = ^acc_i;
        bank_base_o    = {bank_q, {BSH{1'b0}}};
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DW      = 8,
    parameter int BANK_SZ = 8,
    localparam int BBW    = 2 + $clog2(BANK_SZ)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_start,
    input  logic [2:0]     op_code,
    input  logic [DW-1:0]  b_in,
    input  logic           reg_wr,
    input  logic [7:0]     reg_addr,
    input  logic [7:0]     reg_wdata,
    output logic [DW-1:0]  acc_q,
    output logic [DW-1:0]  b_q,
    output logic [7:0]     psw_q,
    output logic [BBW-1:0] bank_base
);
    logic [DW-1:0] as_res, md_lo, md_hi;
    logic          as_cy, as_ac, as_ov, md_ov, md_wr;
    logic          is_sub, is_div, is_carry_op;
    logic          ar_we, acc_ar_we, b_ar_we;
    logic          sw_psw_we, sw_acc_we;
    logic [DW-1:0] ar_acc_val;
    arith_flags_t  ar_flags;

    assign sw_psw_we = reg_wr && (reg_addr == ADDR_STATUS);
    assign sw_acc_we = reg_wr && (reg_addr == ADDR_ACCUM);

    always_comb begin
        is_sub      = 1'b0;
        is_div      = 1'b0;
        is_carry_op = 1'b0;
        ar_we       = 1'b0;
        acc_ar_we   = 1'b0;
        b_ar_we     = 1'b0;
        ar_acc_val  = as_res;
        ar_flags    = '0;
        if (op_start) begin
            unique case (op_code)
                OP_ADD, OP_ADDC: begin
                    is_carry_op = (op_code == OP_ADDC);
                    ar_we       = 1'b1;
                    acc_ar_we   = 1'b1;
                    ar_flags    = '{cy: as_cy, ac: as_ac, ov: as_ov};
                end
                OP_SUBB: begin
                    is_sub      = 1'b1;
                    is_carry_op = 1'b1;
                    ar_we       = 1'b1;
                    acc_ar_we   = 1'b1;
                    ar_flags    = '{cy: as_cy, ac: as_ac, ov: as_ov};
                end
                OP_MUL, OP_DIV: begin
                    is_div     = (op_code == OP_DIV);
                    ar_we      = 1'b1;
                    acc_ar_we  = md_wr;
                    b_ar_we    = md_wr;
                    ar_acc_val = md_lo;
                    ar_flags   = '{cy: 1'b0, ac: 1'b0, ov: md_ov};
                end
                default: ;
            endcase
        end
    end

    acc_alu_addsub #(.DW(DW)) u_addsub (
        .a_i   (acc_q),
        .b_i   (b_in),
        .cin_i (is_carry_op & psw_q[BIT_CY]),
        .sub_i (is_sub),
        .res_o (as_res),
        .cy_o  (as_cy),
        .ac_o  (as_ac),
        .ov_o  (as_ov)
    );

    acc_alu_muldiv #(.DW(DW)) u_muldiv (
        .a_i   (acc_q),
        .b_i   (b_in),
        .div_i (is_div),
        .lo_o  (md_lo),
        .hi_o  (md_hi),
        .ov_o  (md_ov),
        .wr_o  (md_wr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            b_q   <= '0;
        end else begin
            if (acc_ar_we)
                acc_q <= ar_acc_val;
            else if (sw_acc_we)
                acc_q <= reg_wdata[DW-1:0];
            if (b_ar_we)
                b_q <= md_hi;
        end
    end

    acc_alu_status #(.DW(DW), .BANK_SZ(BANK_SZ)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_we_i     (sw_psw_we),
        .sw_data_i   (reg_wdata),
        .ar_we_i     (ar_we),
        .ar_flags_i  (ar_flags),
        .acc_i       (acc_q),
        .psw_o       (psw_q),
        .bank_base_o (bank_base)
    );
endmodule

// File: rtl/acc_alu_core_chk.sv
module acc_alu_core_chk
    import acc_alu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       op_start,
    input logic [2:0] op_code,
    input logic [7:0] b_in,
    input logic       reg_wr,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] acc_q,
    input logic [7:0] b_q,
    input logic [7:0] psw_q,
    input logic [4:0] bank_base
);
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (acc_q == 8'h00 && b_q == 8'h00 && psw_q == 8'h00)); // R7
    AST_PARITY_LIVE: assert property (@(posedge clk) disable iff (!rst_n) psw_q[0] == ($countones(acc_q) % 2 == 1)); // R4
    AST_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_addr == ADDR_STATUS) |=> ($stable(psw_q[5]) && $stable(psw_q[1]) && $stable(bank_base))); // R6
    AST_SW_FIELDS_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && reg_addr == ADDR_STATUS) |=> (psw_q[5] == $past(reg_wdata[5]) && psw_q[4:3] == $past(reg_wdata[4:3]) && psw_q[1] == $past(reg_wdata[1]))); // R11
    AST_MUL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (op_start && op_code == 3'd3) |=> (!psw_q[7] && !psw_q[6] && psw_q[2] == (b_q != 8'h00))); // R3
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (op_start && op_code == 3'd4 && b_in == 8'h00 && !reg_wr) |=> (psw_q[2] && $stable(acc_q) && $stable(b_q))); // R10
    AST_RESERVED_OP: assert property (@(posedge clk) disable iff (!rst_n) (op_start && op_code > 3'd4 && !reg_wr) |=> ($stable(acc_q) && $stable(b_q) && $stable(psw_q))); // R12
endmodule

bind acc_alu_core acc_alu_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_start  (op_start),
    .op_code   (op_code),
    .b_in      (b_in),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .acc_q     (acc_q),
    .b_q       (b_q),
    .psw_q     (psw_q),
    .bank_base (bank_base)
);

// File: tb/acc_alu_core_tb_top.sv
module acc_alu_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [7:0] b_in = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] acc_q, b_q, psw_q;
    logic [4:0] bank_base;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    typedef struct {
        logic [7:0] acc;
        logic [7:0] bv;
        logic [7:0] psw;
        logic [4:0] bank;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    logic [7:0] m_acc = 8'h00, m_b = 8'h00, m_f = 8'h00;

    always #4 clk = ~clk;

    acc_alu_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
        .b_in(b_in), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .acc_q(acc_q), .b_q(b_q), .psw_q(psw_q), .bank_base(bank_base)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int sval(input logic [7:0] v);
        return v[7] ? int'(v) - 256 : int'(v);
    endfunction

    // driver: applies one cycle of stimulus and pushes the model's prediction
    task automatic step(input bit do_op, input logic [2:0] op, input logic [7:0] bv,
                        input bit wr, input logic [7:0] addr, input logic [7:0] wd,
                        input string tag);
        logic [7:0] na, nb, nf;
        int c, r, t;
        exp_t e;
        @(negedge clk);
        op_start = do_op; op_code = op; b_in = bv;
        reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        @(posedge clk);
        #1;
        na = m_acc; nb = m_b; nf = m_f;
        if (wr && addr == 8'hD0) nf = wd;
        if (wr && addr == 8'hE0) na = wd;
        if (do_op && op <= 3'd4) begin
            case (op)
                3'd0, 3'd1: begin
                    c = (op == 3'd1) ? int'(m_f[7]) : 0;
                    r = int'(m_acc) + int'(bv) + c;
                    na = 8'(r);
                    nf[7] = (r > 255);
                    nf[6] = (int'(m_acc[3:0]) + int'(bv[3:0]) + c > 15);
                    t = sval(m_acc) + sval(bv) + c;
                    nf[2] = (t > 127 || t < -128);
                end
                3'd2: begin
                    c = int'(m_f[7]);
                    r = int'(m_acc) - int'(bv) - c;
                    na = 8'(r);
                    nf[7] = (r < 0);
                    nf[6] = (int'(m_acc[3:0]) - int'(bv[3:0]) - c < 0);
                    t = sval(m_acc) - sval(bv) - c;
                    nf[2] = (t > 127 || t < -128);
                end
                3'd3: begin
                    r = int'(m_acc) * int'(bv);
                    na = 8'(r); nb = 8'(r / 256);
                    nf[7] = 1'b0; nf[6] = 1'b0; nf[2] = (r > 255);
                end
                default: begin
                    nf[7] = 1'b0; nf[6] = 1'b0;
                    if (bv == 8'h00) nf[2] = 1'b1;
                    else begin
                        na = 8'(int'(m_acc) / int'(bv));
                        nb = 8'(int'(m_acc) % int'(bv));
                        nf[2] = 1'b0;
                    end
                end
            endcase
        end
        m_acc = na; m_b = nb; m_f = nf;
        e.acc = na; e.bv = nb; e.psw = {nf[7:1], ^na};
        e.bank = {nf[4:3], 3'b000}; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        op_start = 1'b0; reg_wr = 1'b0;
    endtask

    // monitor: compares each prediction at the negedge after its result edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "acc", int'(acc_q), int'(e.acc));
                check(e.tag, "b", int'(b_q), int'(e.bv));
                check(e.tag, "psw", int'(psw_q), int'(e.psw));
                check(e.tag, "bank", int'(bank_base), int'(e.bank));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7", "reset acc", int'(acc_q), 0);
        check("R7", "reset b", int'(b_q), 0);
        check("R5", "reset psw", int'(psw_q), 0);
        check("R6", "reset bank", int'(bank_base), 0);
        rst_n = 1'b1;

        step(0, 3'd0, 8'h00, 1, 8'hE0, 8'h3D, "R7 acc write, R4 odd parity");
        step(0, 3'd0, 8'h00, 1, 8'h80, 8'h55, "R7 other address ignored");
        step(0, 3'd0, 8'h00, 1, 8'hD0, 8'hFF, "R5 status write, R4 parity unwritable");
        step(0, 3'd0, 8'h00, 1, 8'hD0, 8'h08, "R6 bank 1");
        step(0, 3'd0, 8'h00, 1, 8'hD0, 8'h10, "R6 bank 2");
        step(0, 3'd0, 8'h00, 1, 8'hD0, 8'h18, "R6 bank 3");
        step(0, 3'd0, 8'h00, 1, 8'hE0, 8'h7F, "R7 load 7F");
        step(1, 3'd0, 8'h01, 0, 8'h00, 8'h00, "R3 R2 add 7F+1 sign overflow");
        step(0, 3'd0, 8'h00, 1, 8'hD0, 8'h80, "R5 set carry");
        step(0, 3'd0, 8'h00, 1, 8'hE0, 8'hFF, "R7 load FF");
        step(1, 3'd0, 8'h01, 0, 8'h00, 8'h00, "R8 R1 add ignores carry FF+1");
        step(0, 3'd0, 8'h00, 1, 8'hE0, 8'h10, "R7 load 10");
        step(1, 3'd1, 8'h05, 0, 8'h00, 8'h00, "R8 addc with carry set");
        step(1, 3'd1, 8'h7F, 0, 8'h00, 8'h00, "R8 addc carry clear, R3");
        step(0, 3'd0, 8'h00, 1, 8'hE0, 8'h00, "R7 load 00");
        step(1, 3'd2, 8'h01, 0, 8'h00, 8'h00, "R1 R2 subb borrow through zero");
        step(1, 3'd2, 8'h00, 0, 8'h00, 8'h00, "R8 subb borrow-in from carry");
        step(0, 3'd0, 8'h00, 1, 8'hE0, 8'h80, "R7 load 80");
        step(1, 3'd2, 8'h01, 0, 8'h00, 8'h00, "R3 subb 80-1 overflow");
        step(0, 3'd0, 8'h00, 1, 8'hE0, 8'h10, "R7 load 10");
        step(1, 3'd3, 8'h20, 0, 8'h00, 8'h00, "R9 R3 mul product above 255");
        step(0, 3'd0, 8'h00, 1, 8'hE0, 8'h03, "R7 load 03");
        step(1, 3'd3, 8'h05, 0, 8'h00, 8'h00, "R9 R1 mul small product");
        step(0, 3'd0, 8'h00, 1, 8'hE0, 8'hFB, "R7 load FB");
        step(1, 3'd4, 8'h0A, 0, 8'h00, 8'h00, "R10 div quotient remainder");
        step(1, 3'd4, 8'h00, 0, 8'h00, 8'h00, "R10 R3 divide by zero");
        step(1, 3'd5, 8'h33, 0, 8'h00, 8'h00, "R12 reserved code 5");
        step(1, 3'd7, 8'h33, 0, 8'h00, 8'h00, "R12 reserved code 7");
        step(0, 3'd0, 8'h00, 1, 8'hE0, 8'h7F, "R7 load 7F");
        step(1, 3'd0, 8'h01, 1, 8'hD0, 8'h32, "R11 add with status write");
        step(1, 3'd2, 8'h01, 1, 8'hE0, 8'h44, "R11 subb with accumulator write");
        step(1, 3'd3, 8'hFF, 1, 8'hD0, 8'hC6, "R11 mul with status write");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule